// File: doc/BRIEF.md
# Multichannel Overcurrent Fault Reporter

This block gathers the overcurrent comparator outputs of a bank of output stages and presents them to a host through a small register port. Each channel has two views. The filtered view holds a sticky fault message. A fault is accepted only when the raw indication has stayed high for a run of consecutive clock cycles. The live view shows the unfiltered comparator level as it is at the moment of the read.

A status register carries a scan bit: the OR of all live indications. A single control bit turns the filter off for every channel at once, so one cycle of raw overcurrent is enough to latch. Any latched fault pulls an active-low interrupt line. The host clears the latched faults by writing the end-of-interrupt bit. That bit acts only on the write and always reads back as zero. A fault that is still qualified in the clearing cycle is latched again, so it cannot be lost.

Register map with the default of 16 channels:

| Address | Content |
|---|---|
| 0x0, 0x1 | Latched faults for channels 0..7 and 8..15 |
| 0x2, 0x3 | Live indications for channels 0..7 and 8..15 |
| 0x4 | Status |
| 0x5 | Control |

Within each byte, channel i sits at bit i mod 8.

Top module: `oc_fault_reporter`

## Requirements
- R1: While reset is low and just after it, every latched bit is 0, the bypass bit (control bit 0) is 0 and `irq_n` is 1.
- R2: With bypass off, a channel latches at the clock edge that samples its raw input high for the 16th consecutive cycle. A run of 15 cycles latches nothing.
- R3: A single low cycle on a channel's raw input restarts its run of consecutive cycles.
- R4: With bypass on, a raw input sampled high at one clock edge sets that channel's latched bit at that edge.
- R5: Latched channel i reads at bit i mod 8 of address 0x0 (channels 0..7) or 0x1 (channels 8..15).
- R6: Addresses 0x2 and 0x3 return the current raw inputs in the same bit layout as R5, with no filtering and no register stage.
- R7: Status address 0x4 returns the OR of all raw inputs at bit 0 and the OR of all latched bits at bit 1. Its other bits read 0.
- R8: `irq_n` is 0 exactly while at least one latched bit is 1.
- R9: A write to control address 0x5 with bit 1 set clears the latched bits at that edge. Bit 1 of address 0x5 always reads 0, and the same write loads bit 0 into bypass.
- R10: A channel that qualifies (R2 or R4) in the cycle of the clear remains latched after it.
- R11: A latched bit stays 1 after its raw input falls, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | NCH | Raw overcurrent comparator bits, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt, low while any fault is latched |

## Verification
The bench builds the block with its defaults: 16 channels in two bytes per view and a 16-cycle qualification run. This keeps the byte split between addresses 0x0 and 0x1 in play, along with the exact 15-versus-16 cycle edge of the filter. Random raw patterns are biased toward holding bits high, so that long runs, run breaks, bypass toggles and clears that coincide with qualified faults all arise within a few thousand cycles.

// File: rtl/oc_fault_reporter.sv
module oc_fault_reporter #(
  parameter int NCH      = 16,
  parameter int FILT_LEN = 16,
  parameter int AW       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_raw,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic           irq_n
);
  localparam int NB     = (NCH + 7) / 8;
  localparam int PADW   = NB * 8;
  localparam int CW     = $clog2(FILT_LEN) + 1;
  localparam int A_LIVE = NB;
  localparam int A_STAT = 2 * NB;
  localparam int A_CTRL = 2 * NB + 1;

  logic [NCH-1:0] latched;
  logic [NCH-1:0] qual;
  logic           bypass;
  logic           ctrl_wr;
  logic           eoi;
  logic [PADW-1:0] lat_pad, live_pad;
  logic           wdata_unused;

  assign ctrl_wr      = wr_en && (addr == AW'(A_CTRL));
  assign eoi          = ctrl_wr && wdata[1];
  assign wdata_unused = ^wdata[7:2];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] run;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                         run <= '0;
      else if (!oc_raw[g])                run <= '0;
      else if (run != CW'(FILT_LEN - 1))  run <= run + 1'b1;
    assign qual[g] = oc_raw[g] & (bypass | (run == CW'(FILT_LEN - 1)));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) latched <= '0;
    else        latched <= (eoi ? '0 : latched) | qual;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bypass <= 1'b0;
    else if (ctrl_wr) bypass <= wdata[0];

  assign irq_n    = ~|latched;
  assign lat_pad  = PADW'(latched);
  assign live_pad = PADW'(oc_raw);

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr == AW'(b))          rdata = lat_pad[b*8 +: 8];
      if (addr == AW'(A_LIVE + b)) rdata = live_pad[b*8 +: 8];
    end
    if (addr == AW'(A_STAT)) rdata = {6'b0, |latched, |oc_raw};
    if (addr == AW'(A_CTRL)) rdata = {7'b0, bypass};
  end
endmodule

// File: rtl/oc_fault_reporter_chk.sv
module oc_fault_reporter_chk #(
  parameter int NCH = 16,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] oc_raw,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           eoi_bit,
  input logic [7:0]     rdata,
  input logic           irq_n,
  input logic [NCH-1:0] latched,
  input logic           bypass
);
  localparam int NB     = (NCH + 7) / 8;
  localparam int A_STAT = 2 * NB;
  localparam int A_CTRL = 2 * NB + 1;

  logic clr;
  assign clr = wr_en && (addr == AW'(A_CTRL)) && eoi_bit;

  a_r2_new_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latched & ~$past(latched) & ~$past(oc_raw)) == '0));

  a_r4_bypass_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> ((latched & $past(oc_raw)) == $past(oc_raw)));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((latched & $past(latched)) == $past(latched)));

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((latched & ~$past(oc_raw)) == '0));

  a_r9_eoi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(A_CTRL)) |-> (rdata[7:1] == 7'b0));

  a_r7_scan_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(A_STAT)) |-> (rdata[0] == |oc_raw && rdata[7:2] == 6'b0));

  a_r8_irq_low_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|latched) |-> !irq_n);
endmodule

bind oc_fault_reporter oc_fault_reporter_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .wr_en(wr_en), .addr(addr),
  .eoi_bit(wdata[1]), .rdata(rdata), .irq_n(irq_n),
  .latched(latched), .bypass(bypass)
);

// File: tb/tb_oc_fault_reporter.sv
module tb_oc_fault_reporter;
  localparam int NCH = 16;
  localparam int AW  = 4;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [NCH-1:0] oc_raw = '0;
  logic [AW-1:0]  addr = '0;
  logic [7:0]     wdata = '0, rdata;
  logic           irq_n;

  int n_chk = 0, n_fail = 0;
  int m_run [NCH];
  logic [NCH-1:0] m_lat = '0;
  logic m_byp = 0;

  always #2.5 clk = ~clk;

  oc_fault_reporter #(.NCH(NCH), .FILT_LEN(16), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(logic [AW-1:0] a, logic [NCH-1:0] raw);
    case (a)
      0: return m_lat[7:0];
      1: return m_lat[15:8];
      2: return raw[7:0];
      3: return raw[15:8];
      4: return {6'b0, |m_lat, |raw};
      5: return {7'b0, m_byp};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(logic [NCH-1:0] raw, logic wr, logic [AW-1:0] a, logic [7:0] wd);
    logic eoi;
    logic [NCH-1:0] q;
    eoi = wr && a == 5 && wd[1];
    for (int i = 0; i < NCH; i++) begin
      q[i] = raw[i] && (m_byp || m_run[i] >= 15);
      m_run[i] = raw[i] ? ((m_run[i] < 15) ? m_run[i] + 1 : 15) : 0;
    end
    m_lat = (eoi ? '0 : m_lat) | q;
    if (wr && a == 5) m_byp = wd[0];
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) m_run[i] = 0;
    m_lat = '0;
    m_byp = 0;
  endtask

  task automatic step(logic [NCH-1:0] raw, logic wr, logic [AW-1:0] a, logic [7:0] wd, bit chk);
    @(negedge clk);
    oc_raw = raw; wr_en = wr; addr = a; wdata = wd;
    #1;
    if (chk) check("R5/R6/R7 read", rdata, model_read(a, raw));
    @(posedge clk);
    model_step(raw, wr, a, wd);
    #1;
    if (chk) check("R8 irq", {7'b0, irq_n}, {7'b0, ~|m_lat});
  endtask

  task automatic hold(logic [NCH-1:0] raw, int n);
    for (int k = 0; k < n; k++) step(raw, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    wr_en = 0; addr = a;
    #1 v = rdata;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    rd(0, v); check("R1 latched lo in reset", v, 8'h00);
    @(negedge clk) rst_n = 1;
    rd(0, v); check("R1 latched lo", v, 8'h00);
    rd(1, v); check("R1 latched hi", v, 8'h00);
    rd(5, v); check("R1 bypass", v, 8'h00);
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);

    hold(16'h0008, 15); hold(16'h0000, 1);
    rd(0, v); check("R2 15 cycles no latch", v, 8'h00);
    hold(16'h0008, 16);
    rd(0, v); check("R2 latch at 16th", v, 8'h08);
    check("R8 irq low", {7'b0, irq_n}, 8'h00);
    rd(4, v); check("R7 latched flag", v, 8'h03);

    hold(16'h0200, 10); hold(16'h0000, 1); hold(16'h0200, 10);
    rd(1, v); check("R3 restart run", v, 8'h00);
    hold(16'h0200, 6);
    rd(1, v); check("R5 ch9 at addr1 bit1", v, 8'h02);
    hold(16'h0000, 3);
    rd(0, v); check("R11 sticky", v, 8'h08);

    step(16'h0000, 1, 5, 8'h02, 0);
    rd(0, v); check("R9 cleared lo", v, 8'h00);
    rd(1, v); check("R9 cleared hi", v, 8'h00);
    check("R9 irq released", {7'b0, irq_n}, 8'h01);

    step(16'h0000, 1, 5, 8'h03, 0);
    rd(5, v); check("R9 eoi reads 0, bypass loaded", v, 8'h01);
    step(16'h8000, 0, 0, 0, 0);
    rd(1, v); check("R4 bypass one cycle", v, 8'h80);
    step(16'h0001, 1, 5, 8'h03, 0);
    rd(0, v); check("R10 refault in clear cycle", v, 8'h01);
    rd(1, v); check("R10 others cleared", v, 8'h00);
    step(16'h0000, 1, 5, 8'h02, 0);

    hold(16'h0004, 20);
    step(16'h0004, 1, 5, 8'h02, 0);
    rd(0, v); check("R10 filtered refault", v, 8'h04);

    @(negedge clk) oc_raw = 16'hA5C3;
    rd(2, v); check("R6 live lo", v, 8'hC3);
    rd(3, v); check("R6 live hi", v, 8'hA5);
    rd(4, v); check("R7 scan set", v[0] ? 8'h01 : 8'h00, 8'h01);
    @(negedge clk) oc_raw = 16'h0000;
    rd(4, v); check("R7 scan clear", v & 8'h01, 8'h00);

    @(negedge clk) rst_n = 0;
    model_reset();
    @(negedge clk) rst_n = 1;
    begin
      logic [NCH-1:0] raw;
      raw = '0;
      for (int c = 0; c < 4000; c++) begin
        logic wr;
        logic [AW-1:0] a;
        logic [7:0] wd;
        for (int i = 0; i < NCH; i++)
          if ($urandom_range(0, 99) < (raw[i] ? 4 : 6)) raw[i] = ~raw[i];
        a  = AW'($urandom_range(0, 6));
        wr = ($urandom_range(0, 99) < 3);
        wd = {6'b0, ($urandom_range(0, 1) == 1), ($urandom_range(0, 9) == 0)};
        if (wr) a = 5;
        step(raw, wr, a, wd, 1);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule